// File: doc/BRIEF.md
# Line-Control Configurable UART Transmitter

This block serializes one data byte at a time onto an asynchronous serial line. The framing is chosen by an 8-bit line control byte: 5 to 8 data bits, an optional parity bit (even, odd, or a fixed value), and one, one-and-a-half or two stop bits. The control byte also carries a break request that holds the line at logic 0.

Data enters through a valid/ready handshake. Bit timing comes from a one-cycle tick that pulses at 16 times the bit rate, so every bit lasts 16 ticks however many clock cycles fall between ticks. The framing fields are captured when a byte is accepted, so software may rewrite the control byte while a frame is on the line. A break request takes effect on the line in the same cycle. It discards any frame in progress, and the transmitter returns to idle once the request is removed.

Top module: `lc_uart_tx`

## Requirements
- R1: After reset, with the break bit clear, `txd` is 1 and `in_ready` is 1.
- R2: A byte is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle the line carries a start bit of value 0 that lasts 16 ticks.
- R3: Control bits 1:0 set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits follow the start bit least significant bit first, and each lasts 16 ticks. Unused high data bits are not sent.
- R4: Control bit 3 set inserts one parity bit of 16 ticks between the last data bit and the stop period. With bit 3 clear, the stop period follows the last data bit directly.
- R5: With parity enabled and control bit 5 clear, control bit 4 = 1 makes the parity bit the XOR of the sent data bits (even parity). Bit 4 = 0 makes it the inverse of that XOR (odd parity).
- R6: With parity enabled and control bit 5 set, the parity bit equals control bit 4, whatever the data.
- R7: The stop period holds the line at 1. It lasts 16 ticks when control bit 2 is clear, 24 ticks when bit 2 is set with a 5-bit word, and 32 ticks when bit 2 is set with a 6, 7 or 8-bit word.
- R8: `in_ready` is 0 from the cycle after acceptance until the tick edge that ends the stop period. It is 1 in the cycle after that edge.
- R9: Control bits 0 to 5 are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: Control bit 6 set forces `txd` to 0 in the same cycle and holds `in_ready` at 0. A frame in progress is abandoned and is not resumed. When bit 6 clears, the line returns to 1 and `in_ready` to 1.
- R11: Control bit 7 has no effect, and `in_valid` asserted during a break starts no frame.
- R12: Timing counts ticks, not clock cycles. Between ticks the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| lcr_byte | input | 8 | Line control byte (word length, stop bits, parity, break) |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | 8 | Data byte to send |
| in_ready | output | 1 | The transmitter can take a byte |
| txd | output | 1 | Serial line output, idle high |

## Verification
The start bit is due in the first cycle after the acceptance edge. Each later bit and the stop period end on the tick edge that completes their 16, 24 or 32 ticks, and `in_ready` rises in the cycle after the final stop tick. The bench drives the ticks itself and counts those that reach a rising edge. It samples `txd` and `in_ready` at each falling edge and compares them with the bit position it computes from that tick count. The break response is combinational, so the bench checks it a small delay after changing the control byte, before any clock edge. The abandoned frame is then checked through the idle line and the raised ready signal once break clears.

// File: rtl/lctx_pkg.sv
package lctx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  localparam int MAX_WORD = 8;

  // Framing captured at acceptance; stop_len holds ticks (oversample up to 127).
  typedef struct packed {
    logic [3:0] nbits;
    logic       par_on;
    logic       par_val;
    logic [7:0] stop_len;
  } frame_cfg_t;

  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic [7:0] stop_span(input logic two, input logic [1:0] sel,
                                           input int os);
    logic [7:0] r;
    if (!two)              r = 8'(os);
    else if (sel == 2'b00) r = 8'(os + os / 2);
    else                   r = 8'(2 * os);
    return r;
  endfunction

  function automatic logic parity_of(input logic [MAX_WORD-1:0] d, input logic [1:0] sel,
                                     input logic even_sel, input logic stick);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_WORD; i++)
      if (i < int'(word_bits(sel))) x = x ^ d[i];
    if (stick) return even_sel;
    return even_sel ? x : ~x;
  endfunction

endpackage

// File: rtl/lctx_cfg_decode.sv
module lctx_cfg_decode
  import lctx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic [5:0]          lcr_lo,
  input  logic [MAX_WORD-1:0] data,
  output frame_cfg_t          cfg
);

  always_comb begin
    cfg.nbits    = word_bits(lcr_lo[1:0]);
    cfg.par_on   = lcr_lo[3];
    cfg.par_val  = parity_of(data, lcr_lo[1:0], lcr_lo[4], lcr_lo[5]);
    cfg.stop_len = stop_span(lcr_lo[2], lcr_lo[1:0], OVERSAMPLE);
  end

endmodule

// File: rtl/lctx_tick_timer.sv
module lctx_tick_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             phase_end
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last   = (cnt_q == limit - CNT_W'(1));
  assign phase_end = ~clear & tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (tick)    cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end

  // R7: the tick count never runs past the current phase length
  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt_q < limit));

  // R12: without a tick the position inside a bit does not move
  assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/lctx_frame_fsm.sv
module lctx_frame_fsm
  import lctx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  frame_cfg_t          cfg_in,
  input  logic [MAX_WORD-1:0] data_in,
  input  logic                phase_end,
  output phase_e              phase,
  output logic                line_bit,
  output logic [CNT_W-1:0]    phase_len,
  output logic                ev_done
);

  frame_cfg_t          cfg_q;
  logic [MAX_WORD-1:0] shreg;
  logic [3:0]          bit_idx;
  logic                last_data;

  assign last_data = (bit_idx == cfg_q.nbits - 4'd1);
  assign phase_len = (phase == PH_STOP) ? cfg_q.stop_len[CNT_W-1:0] : CNT_W'(OVERSAMPLE);
  assign ev_done   = (phase == PH_STOP) & phase_end & ~abort;

  always_comb begin
    case (phase)
      PH_START:  line_bit = 1'b0;
      PH_DATA:   line_bit = shreg[0];
      PH_PARITY: line_bit = cfg_q.par_val;
      default:   line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cfg_q   <= '0;
      shreg   <= '0;
      bit_idx <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_START;
          cfg_q <= cfg_in;
          shreg <= data_in;
        end
        PH_START: if (phase_end) begin
          phase   <= PH_DATA;
          bit_idx <= '0;
        end
        PH_DATA: if (phase_end) begin
          shreg <= shreg >> 1;
          if (last_data) phase <= cfg_q.par_on ? PH_PARITY : PH_STOP;
          else           bit_idx <= bit_idx + 4'd1;
        end
        PH_PARITY: if (phase_end) phase <= PH_STOP;
        PH_STOP:   if (phase_end) phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // R3: the data index stays inside the captured word length
  assert_bit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (bit_idx < cfg_q.nbits));

  // R4: a parity phase only occurs when parity was enabled at acceptance
  assert_parity_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PARITY) |-> cfg_q.par_on);

  // R9: the captured framing stays fixed for the whole frame
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(cfg_q));

endmodule

// File: rtl/lc_uart_tx.sv
module lc_uart_tx
  import lctx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [7:0] lcr_byte,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);

  frame_cfg_t       cfg_now;
  phase_e           phase;
  logic             line_bit;
  logic [CNT_W-1:0] phase_len;
  logic             phase_end;
  logic             brk, idle;
  logic             ev_accept, ev_abort, ev_done;
  logic             lcr_unused;

  assign lcr_unused = lcr_byte[7];
  assign brk        = lcr_byte[6];
  assign idle       = (phase == PH_IDLE);
  assign in_ready   = idle & ~brk;
  assign ev_accept  = in_valid & in_ready;
  assign ev_abort   = brk & ~idle;
  assign txd        = line_bit & ~brk;

  lctx_cfg_decode #(.OVERSAMPLE(OVERSAMPLE)) u_decode (
    .lcr_lo (lcr_byte[5:0]),
    .data   (in_data),
    .cfg    (cfg_now)
  );

  lctx_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (idle | brk),
    .tick      (tick16),
    .limit     (phase_len),
    .phase_end (phase_end)
  );

  lctx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_accept),
    .abort     (ev_abort),
    .cfg_in    (cfg_now),
    .data_in   (in_data),
    .phase_end (phase_end),
    .phase     (phase),
    .line_bit  (line_bit),
    .phase_len (phase_len),
    .ev_done   (ev_done)
  );

  // R2: the start bit appears the cycle after acceptance
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !txd);

  // R8: ready drops once a frame is accepted
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !in_ready);

  // R8: ready returns right after the final stop tick unless break is requested
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (in_ready || lcr_byte[6]));

  // R10: break abandons the frame in progress
  assert_break_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (phase == PH_IDLE));

endmodule

// File: tb/lc_uart_tx_test.sv
`timescale 1ns/1ps
module lc_uart_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] lcr_byte = 8'h00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lc_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lcr_byte(lcr_byte),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Sends one frame and compares every cycle against a tick-count model.
  task automatic run_frame(input logic [7:0] lcr, input logic [7:0] d, input int per, input string tag);
    int n, p, s, total, t, cyc, r;
    logic x, pv, e_txd;
    bit done;
    bit bad[5];
    string lbl[5];
    lbl[0] = "R2 start"; lbl[1] = "R3 data"; lbl[2] = "R4 R5 R6 parity";
    lbl[3] = "R7 stop";  lbl[4] = "R8 ready";
    for (int i = 0; i < 5; i++) bad[i] = 1'b0;
    n = 5 + int'(lcr[1:0]);
    p = int'(lcr[3]);
    s = !lcr[2] ? 16 : ((lcr[1:0] == 2'b00) ? 24 : 32);
    x = 1'b0;
    for (int i = 0; i < n; i++) x = x ^ d[i];
    pv = lcr[5] ? lcr[4] : (lcr[4] ? x : ~x);
    total = 16 * (1 + n + p) + s;

    @(negedge clk);
    lcr_byte = lcr; in_data = d; in_valid = 1'b1; tick16 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lcr_byte = (lcr ^ 8'h2B) & 8'hBF;   // R9: rewrite framing mid-frame
    in_data  = ~d;
    t = 0; cyc = 0; done = 1'b0;
    while (!done && cyc < 4000) begin
      if (t >= total) begin
        if (in_ready !== 1'b1 && !bad[4]) begin
          bad[4] = 1'b1;
          $display("FAIL %s %s: in_ready act=%0b exp=1 tick=%0d", tag, lbl[4], in_ready, t);
        end
        if (txd !== 1'b1 && !bad[3]) begin
          bad[3] = 1'b1;
          $display("FAIL %s %s: txd act=%0b exp=1 tick=%0d", tag, lbl[3], txd, t);
        end
        done = 1'b1;
      end else begin
        if (t < 16) begin r = 0; e_txd = 1'b0; end
        else if (t < 16 * (1 + n)) begin r = 1; e_txd = d[(t - 16) / 16]; end
        else if (p == 1 && t < 16 * (2 + n)) begin r = 2; e_txd = pv; end
        else begin r = 3; e_txd = 1'b1; end
        if (txd !== e_txd && !bad[r]) begin
          bad[r] = 1'b1;
          $display("FAIL %s %s: txd act=%0b exp=%0b tick=%0d", tag, lbl[r], txd, e_txd, t);
        end
        if (in_ready !== 1'b0 && !bad[4]) begin
          bad[4] = 1'b1;
          $display("FAIL %s %s: in_ready act=%0b exp=0 tick=%0d", tag, lbl[4], in_ready, t);
        end
        tick16 = ((cyc % per) == 0);
        cyc++;
        @(posedge clk);
        if (tick16) t++;
        @(negedge clk);
      end
    end
    tick16 = 1'b0;
    if (!done) begin
      fails++;
      $display("FAIL %s frame never completed act=%0d exp=%0d", tag, t, total);
    end
    for (int i = 0; i < 5; i++) begin
      if (i != 2 || p == 1) begin
        checks++;
        if (bad[i]) fails++;
      end
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(txd === 1'b1 && in_ready === 1'b1, "R1 reset idle", {30'd0, txd, in_ready}, 32'h3);

    // R3 R4 R5 R6 R7 R8 R9 R11: sweep all framing codes, bit 7 toggled
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        logic [7:0] lc;
        case (k)
          0: d = 8'h00;
          1: d = 8'hFF;
          2: d = 8'hA5;
          default: d = 8'(c * 29 + 7);
        endcase
        lc = {k[0], 1'b0, c[5:0]};
        run_frame(lc, d, 1, "R9 R11 sweep");
      end
    end

    // R12: sparse ticks, timing counted in ticks
    run_frame(8'h1B, 8'h96, 3, "R12 sparse");
    run_frame(8'h04, 8'h15, 4, "R12 R7 sparse");
    run_frame(8'h3F, 8'hC3, 2, "R12 R6 sparse");

    // R10: break while idle
    @(negedge clk);
    lcr_byte = 8'h40;
    #1;
    chk(txd === 1'b0 && in_ready === 1'b0, "R10 break in idle", {30'd0, txd, in_ready}, 32'h0);
    lcr_byte = 8'h00;
    #1;
    chk(txd === 1'b1 && in_ready === 1'b1, "R10 break release idle", {30'd0, txd, in_ready}, 32'h3);

    // R10: break during a frame
    @(negedge clk);
    lcr_byte = 8'h03; in_data = 8'h55; in_valid = 1'b1; tick16 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(in_ready === 1'b0, "R8 busy before break", {31'd0, in_ready}, 32'h0);
    lcr_byte = 8'h43;
    #1;
    chk(txd === 1'b0, "R10 break forces line low", {31'd0, txd}, 32'h0);
    @(negedge clk);
    chk(in_ready === 1'b0, "R10 ready low in break", {31'd0, in_ready}, 32'h0);
    in_valid = 1'b1; in_data = 8'hFF;   // R11: offered during break
    ok = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (txd !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R10 break held", {31'd0, ok}, 32'h1);
    in_valid = 1'b0;
    lcr_byte = 8'h03;
    #1;
    chk(txd === 1'b1 && in_ready === 1'b1, "R10 idle after break", {30'd0, txd, in_ready}, 32'h3);
    ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (txd !== 1'b1 || in_ready !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R10 R11 no resumed or new frame", {31'd0, ok}, 32'h1);
    tick16 = 1'b0;

    // R2: a frame still works after break
    run_frame(8'h0B, 8'h3C, 1, "R2 after break");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule